// File: doc/BRIEF.md
# AES Column Mixing Unit

This block applies the AES column-mixing step to a state held as four-byte columns. Each byte is treated as an element of GF(2^8), reduced by the polynomial x^8+x^4+x^3+x+1. Each column is treated as a four-term polynomial and multiplied, modulo x^4+1, by a fixed polynomial. A mode bit selects the polynomial:

- The forward (encryption) polynomial is {03}x^3+{01}x^2+{01}x+{02}.
- The inverse (decryption) polynomial is {0B}x^3+{0D}x^2+{09}x+{0E}.

Row rotation, byte substitution and key handling are done elsewhere.

A parameter sets how many column lanes work in parallel: one lane for a 32-bit column, or four lanes for a whole 128-bit state. Each lane builds every multiple from shift-and-conditional-XOR doubling stages. The inverse mode reuses the forward network: a small preconditioning stage folds the extra multiples of four into the column before it enters the shared forward XOR tree. A second parameter picks either a registered output with a clock enable (the default) or a purely combinational path.

Top module: `mixcol_unit`

## Requirements
- R1: With `inv_mode`=0, each output byte r of a column is {02}·a[r] ^ {03}·a[r+1] ^ a[r+2] ^ a[r+3], with indices taken mod 4. Byte 0 of a column is its most significant byte. Column 0 of the state occupies the most significant 32 bits.
- R2: With `inv_mode`=1, each output byte r is {0E}·a[r] ^ {0B}·a[r+1] ^ {0D}·a[r+2] ^ {09}·a[r+3], with indices taken mod 4.
- R3: In forward mode, the column db,13,53,45 (word 32'hdb135345) becomes 8e,4d,a1,bc (32'h8e4da1bc).
- R4: In inverse mode, the column 32'h8e4da1bc becomes 32'hdb135345.
- R5: Feeding the forward result back through the inverse mode returns the original column, for any input.
- R6: Doubling reduces by 0x1B when the top bit is set. So the forward image of column 80,00,00,00 is 1b,80,80,9b. A column whose four bytes are equal passes through unchanged in both modes.
- R7: Every lane transforms only its own column. All lanes use the single `inv_mode` bit.
- R8: With the registered output:
  - A result appears on `state_out`, with `out_valid` high, in the cycle after `in_valid` is sampled high.
  - `out_valid` is low after any cycle without `in_valid`.
  - `state_out` holds its value while `in_valid` is low.
  - Reset clears both `out_valid` and `state_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input column(s) valid; acts as the output register enable |
| inv_mode | input | 1 | 0 selects the forward matrix, 1 the inverse matrix |
| state_in | input | 32*LANES | Input columns, column 0 in the top bits |
| out_valid | output | 1 | Result valid |
| state_out | output | 32*LANES | Transformed columns |

## Verification
The bench builds the unit with LANES=4 and PIPE=1. This puts four independent columns in one word, so a fault that mixes lanes or ties a lane to the wrong mode shows up in R7 checks. It also exercises the registered path, so the latency, hold and reset behaviour of R8 is observable. A new state can be accepted every cycle, so back-to-back forward and inverse items pass through the scoreboard. This lets the bench feed one result straight back in for the round-trip check.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int COL_W  = BYTE_W * ROWS;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

  // index [ROWS-1] is row 0 (most significant byte)
  typedef logic [ROWS-1:0][BYTE_W-1:0] col_t;
endpackage

// File: rtl/gf_dbl.sv
module gf_dbl #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1B
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] shifted;
  always_comb begin
    shifted = {x[W-2:0], 1'b0};
    y       = x[W-1] ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/mix_precond.sv
// Inverse preconditioning: a0,a2 ^= 4(a0^a2); a1,a3 ^= 4(a1^a3).
// The forward network applied afterwards yields the inverse matrix.
module mix_precond
  import mixcol_pkg::*;
(
  input  col_t a,
  input  logic inv,
  output col_t b
);
  logic [BYTE_W-1:0] sum_even, sum_odd;
  logic [BYTE_W-1:0] dbl_even, dbl_odd;
  logic [BYTE_W-1:0] quad_even, quad_odd;

  always_comb begin
    sum_even = a[ROWS-1] ^ a[ROWS-3];
    sum_odd  = a[ROWS-2] ^ a[ROWS-4];
  end

  gf_dbl #(.W(BYTE_W), .POLY(RED_POLY)) u_de0 (.x(sum_even), .y(dbl_even));
  gf_dbl #(.W(BYTE_W), .POLY(RED_POLY)) u_de1 (.x(dbl_even), .y(quad_even));
  gf_dbl #(.W(BYTE_W), .POLY(RED_POLY)) u_do0 (.x(sum_odd),  .y(dbl_odd));
  gf_dbl #(.W(BYTE_W), .POLY(RED_POLY)) u_do1 (.x(dbl_odd),  .y(quad_odd));

  always_comb begin
    b = a;
    if (inv) begin
      b[ROWS-1] = a[ROWS-1] ^ quad_even;
      b[ROWS-3] = a[ROWS-3] ^ quad_even;
      b[ROWS-2] = a[ROWS-2] ^ quad_odd;
      b[ROWS-4] = a[ROWS-4] ^ quad_odd;
    end
  end
endmodule

// File: rtl/mix_fwd.sv
// Forward matrix: out[r] = 2a[r] ^ 3a[r+1] ^ a[r+2] ^ a[r+3]
module mix_fwd
  import mixcol_pkg::*;
(
  input  col_t a,
  output col_t y
);
  col_t d;

  for (genvar r = 0; r < ROWS; r++) begin : g_dbl
    gf_dbl #(.W(BYTE_W), .POLY(RED_POLY)) u_dbl (
      .x(a[ROWS-1-r]),
      .y(d[ROWS-1-r])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int R1I = (r + 1) % ROWS;
    localparam int R2I = (r + 2) % ROWS;
    localparam int R3I = (r + 3) % ROWS;
    assign y[ROWS-1-r] = d[ROWS-1-r] ^ d[ROWS-1-R1I] ^ a[ROWS-1-R1I]
                       ^ a[ROWS-1-R2I] ^ a[ROWS-1-R3I];
  end
endmodule

// File: rtl/mix_lane.sv
module mix_lane
  import mixcol_pkg::*;
(
  input  col_t a,
  input  logic inv,
  output col_t y
);
  col_t pre;
  mix_precond u_pre (.a(a), .inv(inv), .b(pre));
  mix_fwd     u_fwd (.a(pre), .y(y));
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
  import mixcol_pkg::*;
#(
  parameter int LANES = 4,
  parameter bit PIPE  = 1'b1,
  localparam int W    = COL_W * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         inv_mode,
  input  logic [W-1:0] state_in,
  output logic         out_valid,
  output logic [W-1:0] state_out
);
  logic [W-1:0] mixed;

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    col_t lane_in, lane_out;
    assign lane_in = state_in[W-1-COL_W*c -: COL_W];
    mix_lane u_lane (.a(lane_in), .inv(inv_mode), .y(lane_out));
    assign mixed[W-1-COL_W*c -: COL_W] = lane_out;
  end

  if (PIPE) begin : g_reg
    logic [W-1:0] data_q, data_d;
    logic         vld_q,  vld_d;

    always_comb begin
      data_d = in_valid ? mixed : data_q;
      vld_d  = in_valid;
    end

    // reset is expected to be released synchronously upstream
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        data_q <= data_d;
        vld_q  <= vld_d;
      end
    end

    assign state_out = data_q;
    assign out_valid = vld_q;
  end else begin : g_comb
    assign state_out = mixed;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/mixcol_unit_chk.sv
module mixcol_unit_chk #(
  parameter bit PIPE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        inv_mode,
  input logic [31:0] in_col0,
  input logic        out_valid,
  input logic [31:0] out_col0
);
  logic uniform;
  assign uniform = (in_col0[31:24] == in_col0[23:16]) &&
                   (in_col0[23:16] == in_col0[15:8]) &&
                   (in_col0[15:8]  == in_col0[7:0]);

  if (PIPE) begin : g_seq
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_col0));
    a_r6_uniform_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && uniform) |=> (out_col0 == $past(in_col0)));
    a_r3_fwd_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !inv_mode && in_col0 == 32'hdb135345) |=> (out_col0 == 32'h8e4da1bc));
    a_r4_inv_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && inv_mode && in_col0 == 32'h8e4da1bc) |=> (out_col0 == 32'hdb135345));
  end else begin : g_comb
    always_comb begin
      if (rst_n && in_valid && uniform)
        a_r6_uniform_comb: assert (out_col0 == in_col0);
    end
  end
endmodule

bind mixcol_unit mixcol_unit_chk #(.PIPE(PIPE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .inv_mode (inv_mode),
  .in_col0  (state_in[W-1 -: 32]),
  .out_valid(out_valid),
  .out_col0 (state_out[W-1 -: 32])
);

// File: tb/sim_mixcol_unit.sv
`timescale 1ns/1ps
module sim_mixcol_unit;
  localparam int LANES = 4;
  localparam int W = 32 * LANES;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic inv_mode;
  logic [W-1:0] state_in;
  logic out_valid;
  logic [W-1:0] state_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  mixcol_unit #(.LANES(LANES), .PIPE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
    .state_in(state_in), .out_valid(out_valid), .state_out(state_out)
  );

  // reference multiply, bit-serial
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] ref_col(input logic [31:0] col, input bit inv);
    logic [7:0] c[4];
    logic [7:0] a[4];
    logic [31:0] r = '0;
    if (inv) begin c[0]=8'h0e; c[1]=8'h0b; c[2]=8'h0d; c[3]=8'h09; end
    else     begin c[0]=8'h02; c[1]=8'h03; c[2]=8'h01; c[3]=8'h01; end
    for (int k = 0; k < 4; k++) a[k] = col[31-8*k -: 8];
    for (int row = 0; row < 4; row++) begin
      logic [7:0] s = 8'h00;
      for (int k = 0; k < 4; k++) s ^= gmul(c[(k - row + 4) % 4], a[k]);
      r[31-8*row -: 8] = s;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_state(input logic [W-1:0] st, input bit inv);
    logic [W-1:0] r;
    for (int c = 0; c < LANES; c++) r[W-1-32*c -: 32] = ref_col(st[W-1-32*c -: 32], inv);
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: apply one item and push its expectation
  task automatic drive(input bit inv, input logic [W-1:0] st,
                       input logic [W-1:0] exp, input string req);
    @(posedge clk); #1;
    in_valid = 1'b1; inv_mode = inv; state_in = st;
    exp_q.push_back(exp); tag_q.push_back(req);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; inv_mode = 1'b0; state_in = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: out_valid with no pending item, actual %h expected none", state_out);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, state_out, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] st, r, held;
    rst_n = 1'b0; in_valid = 1'b0; inv_mode = 1'b0; state_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset data", state_out, '0);
    check("R8 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;

    // R3 / R4 check vectors in every lane
    st = {4{32'hdb135345}};
    drive(1'b0, st, {4{32'h8e4da1bc}}, "R3 fwd vector");
    drive(1'b1, {4{32'h8e4da1bc}}, st, "R4 inv vector");

    // R6 reduction and uniform columns
    drive(1'b0, {32'h80000000, 32'h00000000, 32'h01010101, 32'hffffffff},
          {32'h1b80809b, 32'h00000000, 32'h01010101, 32'hffffffff}, "R6 reduce/uniform fwd");
    drive(1'b1, {32'h80808080, 32'h5a5a5a5a, 32'h00000000, 32'hc3c3c3c3},
          {32'h80808080, 32'h5a5a5a5a, 32'h00000000, 32'hc3c3c3c3}, "R6 uniform inv");

    // R7 lane independence: only lane 2 nonzero
    st = {32'h0, 32'h0, 32'hdb135345, 32'h0};
    drive(1'b0, st, {32'h0, 32'h0, 32'h8e4da1bc, 32'h0}, "R7 lane isolation");

    // R1 / R2 mixed patterns
    for (int i = 0; i < 24; i++) begin
      st = {$urandom, $urandom, $urandom, $urandom};
      drive(i[0], st, ref_state(st, i[0]), i[0] ? "R2 inverse pattern" : "R1 forward pattern");
    end

    // R8 hold while idle
    idle();
    @(posedge clk); #1;
    held = state_out;
    repeat (3) @(posedge clk);
    #1;
    check("R8 hold data", state_out, held);
    check("R8 idle valid", {{(W-1){1'b0}}, out_valid}, '0);

    // R5 round trip with feedback of the result
    for (int i = 0; i < 8; i++) begin
      st = {$urandom, $urandom, $urandom, $urandom};
      drive(1'b0, st, ref_state(st, 1'b0), "R5 fwd leg");
      @(posedge clk); #1;
      r = state_out;
      in_valid = 1'b1; inv_mode = 1'b1; state_in = r;
      exp_q.push_back(st); tag_q.push_back("R5 round trip");
    end
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R8 queue drained", W'(exp_q.size()), '0);
    finish_run();
  end
endmodule